// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Counters

This block sits beside the fetch stage of a pipelined processor and supplies the next fetch address. It keeps a small direct-mapped table. Each slot holds a valid bit, an address tag, a cached branch target and a two-bit saturating direction counter. Fetch presents its current address. One cycle later the block returns the address to fetch next. That address is the cached target when the slot holds this branch and the counter leans taken. In every other case it is the sequential address, the fetch address plus 4.

When a branch resolves later in the pipeline, the pipeline hands the block four things: the branch address, the real direction, the computed target, and the prediction that fetch acted on for that branch. The block either creates the slot (on first execution) or trains it. When the earlier prediction was wrong, it raises a one-cycle flush together with the corrected fetch address. A wrong direction counts as wrong, and so does a taken branch that went to a different target than the one predicted.

The counter gives the predictor hysteresis. A branch that is strongly biased keeps its prediction after one contrary outcome.

Top module: `btb_predictor`

## Requirements
- R1: After synchronous reset every slot is invalid. A lookup then reports a miss, no taken prediction, and a next address of lk_pc+4. `flush` and `pred_valid` are low while reset is applied.
- R2: A lookup accepted on one rising edge drives `pred_valid`, `pred_hit`, `pred_taken` and `pred_pc` after that same edge, for one cycle. `pred_pc` is the stored target when `pred_taken` is 1 and lk_pc+4 otherwise.
- R3: A lookup hits only when the slot selected by lk_pc[5:2] is valid and its stored tag equals lk_pc[31:6]. `pred_taken` is 1 exactly when the lookup hits and bit 1 of the slot's counter is 1.
- R4: An update that misses allocates the slot. It stores the tag and the computed target, and it sets the counter to 2'b10 (weakly taken) when the branch was taken and to 2'b01 (weakly not taken) when it was not.
- R5: An update that hits moves the counter one step toward 2'b11 on taken and toward 2'b00 on not taken. The counter saturates at both ends. The encodings are 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken.
- R6: A slot at 2'b11 still predicts taken after one not-taken outcome.
- R7: An update that was predicted taken but resolved not taken raises `flush` on the following cycle, with `flush_pc` equal to upd_pc+4.
- R8: An update that was predicted not taken but resolved taken raises `flush` on the following cycle, with `flush_pc` equal to `upd_target`.
- R9: An update that was predicted taken, resolved taken, but reports a target different from the predicted one raises `flush` with `flush_pc` equal to `upd_target`. The slot's stored target is replaced by that new target.
- R10: An update whose prediction matched both the direction and, for a taken branch, the target leaves `flush` low on the following cycle.
- R11: When a lookup and an update select the same slot in the same cycle, the lookup result reflects the slot contents from before that update.
- R12: An update whose tag differs from a valid slot's tag replaces that slot, and the counter restarts as in R4. A later lookup of the old address then misses.
- R13: A not-taken update that hits leaves the stored target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request from fetch |
| lk_pc | input | 32 | Fetch address to look up |
| pred_valid | output | 1 | Prediction result present this cycle |
| pred_hit | output | 1 | Lookup found a matching valid slot |
| pred_taken | output | 1 | Branch predicted taken |
| pred_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual branch direction |
| upd_target | input | 32 | Computed branch target |
| upd_pred_taken | input | 1 | Direction that fetch predicted for this branch |
| upd_pred_target | input | 32 | Next address that fetch used when it predicted taken |
| flush | output | 1 | Misprediction: squash younger work and redirect |
| flush_pc | output | 32 | Corrected fetch address |

## Verification
Both result paths are due exactly one rising edge after the stimulus. The lookup outputs follow the edge that captured `lk_valid`. `flush` and `flush_pc` follow the edge that captured `upd_valid`. The bench drives each request on a falling edge, withdraws it on the next falling edge, and samples at that moment, so every sample falls halfway through the cycle in which the result is due. Table contents written by an update become visible to a lookup issued on a later edge. In the same-edge case (R11) the bench expects the old contents, and it commits its own model only after checking the lookup.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // one saturating step toward taken (up=1) or not taken (up=0)
  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    if (up) begin
      return (c == CTR_ST) ? c : ctr_t'(c + 2'd1);
    end
    return (c == CTR_SNT) ? c : ctr_t'(c - 2'd1);
  endfunction

  // starting state of a freshly allocated slot
  function automatic ctr_t ctr_seed(input logic up);
    return up ? CTR_WT : CTR_WNT;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  parameter int TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  // registered lookup port
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit_q,
  output ctr_t             rd_ctr_q,
  output logic [TGT_W-1:0] rd_tgt_q,
  // asynchronous peek used by the resolve side
  input  logic [IDX_W-1:0] pk_idx,
  output logic             pk_vld,
  output logic [TAG_W-1:0] pk_tag,
  output ctr_t             pk_ctr,
  // write port
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  ctr_t             wr_ctr,
  input  logic             wr_tgt_en,
  input  logic [TGT_W-1:0] wr_tgt
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0] tag_q   [DEPTH];
  ctr_t             cnt_q   [DEPTH];
  logic [TGT_W-1:0] tgt_mem [DEPTH];

  // valid bits need reset; lookup hit/ctr registered from old contents
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      rd_hit_q <= 1'b0;
      rd_ctr_q <= CTR_SNT;
    end else begin
      if (we) begin
        vld_q[wr_idx] <= 1'b1;
      end
      if (rd_en) begin
        rd_hit_q <= vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_ctr_q <= cnt_q[rd_idx];
      end
    end
  end

  // tag and counter arrays: small, no reset, distributed-RAM friendly
  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[wr_idx] <= wr_tag;
      cnt_q[wr_idx] <= wr_ctr;
    end
  end

  // target array: synchronous read-before-write, block-RAM style
  always_ff @(posedge clk) begin
    if (we && wr_tgt_en) begin
      tgt_mem[wr_idx] <= wr_tgt;
    end
    if (rd_en) begin
      rd_tgt_q <= tgt_mem[rd_idx];
    end
  end

  assign pk_vld = vld_q[pk_idx];
  assign pk_tag = tag_q[pk_idx];
  assign pk_ctr = cnt_q[pk_idx];

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (vld_q[$past(wr_idx)] && (cnt_q[$past(wr_idx)] == $past(wr_ctr))
            && (tag_q[$past(wr_idx)] == $past(wr_tag))));

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int TAG_W = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken,
  input  logic [PC_W-1:0]  upd_target,
  input  logic             upd_pred_taken,
  input  logic [PC_W-1:0]  upd_pred_target,
  // current slot contents
  input  logic             ent_vld,
  input  logic [TAG_W-1:0] ent_tag,
  input  ctr_t             ent_ctr,
  // table write
  output logic             we,
  output logic [IDX_W-1:0] wr_idx,
  output logic [TAG_W-1:0] wr_tag,
  output ctr_t             wr_ctr,
  output logic             wr_tgt_en,
  output logic [PC_W-1:0]  wr_tgt,
  // redirect
  output logic             flush_q,
  output logic [PC_W-1:0]  flush_pc_q
);

  logic            ent_hit;
  logic            dir_wrong;
  logic            tgt_wrong;
  logic            flush_d;
  logic [PC_W-1:0] fix_pc;

  assign wr_idx  = upd_pc[IDX_W+1:2];
  assign wr_tag  = upd_pc[PC_W-1:IDX_W+2];
  assign ent_hit = ent_vld && (ent_tag == wr_tag);

  always_comb begin
    we        = upd_valid;
    wr_ctr    = ent_hit ? ctr_step(ent_ctr, upd_taken) : ctr_seed(upd_taken);
    // keep an existing target on not-taken; fresh slots always record one
    wr_tgt_en = upd_taken || !ent_hit;
    wr_tgt    = upd_target;
  end

  always_comb begin
    dir_wrong = upd_pred_taken != upd_taken;
    tgt_wrong = upd_pred_taken && upd_taken && (upd_pred_target != upd_target);
    flush_d   = upd_valid && (dir_wrong || tgt_wrong);
    fix_pc    = upd_taken ? upd_target : upd_pc + PC_W'(4);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q    <= 1'b0;
      flush_pc_q <= '0;
    end else begin
      flush_q    <= flush_d;
      flush_pc_q <= fix_pc;
    end
  end

  // R5
  ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (we && ent_hit) |-> ((wr_ctr == ent_ctr) || (wr_ctr == ctr_t'(ent_ctr + 2'd1))
                         || (wr_ctr == ctr_t'(ent_ctr - 2'd1))));

  // R7
  nt_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_pred_taken && !upd_taken)
      |=> (flush_q && (flush_pc_q == $past(upd_pc) + PC_W'(4))));

  // R10
  no_false_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && (upd_pred_taken == upd_taken)
     && (!upd_taken || (upd_pred_target == upd_target))) |=> !flush_q);

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_valid,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_pred_taken,
  input  logic [PC_W-1:0] upd_pred_target,
  output logic            flush,
  output logic [PC_W-1:0] flush_pc
);

  localparam int TAG_W = PC_W - IDX_W - 2;

  logic             pv_q;
  logic [PC_W-1:0]  seq_q;
  logic             rd_hit_q;
  ctr_t             rd_ctr_q;
  logic [PC_W-1:0]  rd_tgt_q;
  logic [IDX_W-1:0] up_idx;
  logic             pk_vld;
  logic [TAG_W-1:0] pk_tag;
  ctr_t             pk_ctr;
  logic             we;
  logic [TAG_W-1:0] wr_tag;
  ctr_t             wr_ctr;
  logic             wr_tgt_en;
  logic [PC_W-1:0]  wr_tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv_q  <= 1'b0;
      seq_q <= '0;
    end else begin
      pv_q  <= lk_valid;
      if (lk_valid) begin
        seq_q <= lk_pc + PC_W'(4);
      end
    end
  end

  btb_store #(
    .IDX_W(IDX_W),
    .TAG_W(TAG_W),
    .TGT_W(PC_W)
  ) store_i (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (lk_valid),
    .rd_idx    (lk_pc[IDX_W+1:2]),
    .rd_tag    (lk_pc[PC_W-1:IDX_W+2]),
    .rd_hit_q  (rd_hit_q),
    .rd_ctr_q  (rd_ctr_q),
    .rd_tgt_q  (rd_tgt_q),
    .pk_idx    (up_idx),
    .pk_vld    (pk_vld),
    .pk_tag    (pk_tag),
    .pk_ctr    (pk_ctr),
    .we        (we),
    .wr_idx    (up_idx),
    .wr_tag    (wr_tag),
    .wr_ctr    (wr_ctr),
    .wr_tgt_en (wr_tgt_en),
    .wr_tgt    (wr_tgt)
  );

  btb_resolve #(
    .PC_W (PC_W),
    .IDX_W(IDX_W),
    .TAG_W(TAG_W)
  ) resolve_i (
    .clk             (clk),
    .rst             (rst),
    .upd_valid       (upd_valid),
    .upd_pc          (upd_pc),
    .upd_taken       (upd_taken),
    .upd_target      (upd_target),
    .upd_pred_taken  (upd_pred_taken),
    .upd_pred_target (upd_pred_target),
    .ent_vld         (pk_vld),
    .ent_tag         (pk_tag),
    .ent_ctr         (pk_ctr),
    .we              (we),
    .wr_idx          (up_idx),
    .wr_tag          (wr_tag),
    .wr_ctr          (wr_ctr),
    .wr_tgt_en       (wr_tgt_en),
    .wr_tgt          (wr_tgt),
    .flush_q         (flush),
    .flush_pc_q      (flush_pc)
  );

  assign pred_valid = pv_q;
  assign pred_hit   = pv_q && rd_hit_q;
  assign pred_taken = pred_hit && ctr_says_taken(rd_ctr_q);
  assign pred_pc    = pred_taken ? rd_tgt_q : seq_q;

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!pred_valid && !flush));

  // R2
  pred_valid_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid);

  // R3
  miss_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_taken) |-> (pred_pc == $past(lk_pc) + PC_W'(4)));

  // R3
  miss_no_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_hit) |-> !pred_taken);

  // R10
  flush_src_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(upd_valid));

endmodule

// File: tb/btb_predictor_tb_top.sv
module btb_predictor_tb_top;

  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int TAG_W = PC_W - IDX_W - 2;
  localparam int DEPTH = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst;
  logic            lk_valid;
  logic [PC_W-1:0] lk_pc;
  logic            pred_valid, pred_hit, pred_taken;
  logic [PC_W-1:0] pred_pc;
  logic            upd_valid, upd_taken, upd_pred_taken;
  logic [PC_W-1:0] upd_pc, upd_target, upd_pred_target;
  logic            flush;
  logic [PC_W-1:0] flush_pc;

  always #5 clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_pc(pred_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
    .upd_pred_taken(upd_pred_taken), .upd_pred_target(upd_pred_target),
    .flush(flush), .flush_pc(flush_pc)
  );

  // reference table kept by the bench
  logic             m_vld [DEPTH];
  logic [TAG_W-1:0] m_tag [DEPTH];
  logic [1:0]       m_ctr [DEPTH];
  logic [PC_W-1:0]  m_tgt [DEPTH];

  int n_run  = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what,
                     input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int ix(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  task automatic m_predict(input logic [PC_W-1:0] pc, output logic h,
                           output logic t, output logic [PC_W-1:0] npc);
    h   = m_vld[ix(pc)] && (m_tag[ix(pc)] == pc[PC_W-1:IDX_W+2]);
    t   = h && (m_ctr[ix(pc)] >= 2'd2);
    npc = t ? m_tgt[ix(pc)] : pc + 32'd4;
  endtask

  task automatic m_train(input logic [PC_W-1:0] pc, input logic tk,
                         input logic [PC_W-1:0] tgt);
    int  i;
    logic h;
    i = ix(pc);
    h = m_vld[i] && (m_tag[i] == pc[PC_W-1:IDX_W+2]);
    if (h) begin
      if (tk && m_ctr[i] != 2'd3) m_ctr[i] = m_ctr[i] + 2'd1;
      if (!tk && m_ctr[i] != 2'd0) m_ctr[i] = m_ctr[i] - 2'd1;
      if (tk) m_tgt[i] = tgt;
    end else begin
      m_vld[i] = 1'b1;
      m_tag[i] = pc[PC_W-1:IDX_W+2];
      m_ctr[i] = tk ? 2'd2 : 2'd1;
      m_tgt[i] = tgt;
    end
  endtask

  task automatic check_pred(input string req, input logic h, input logic t,
                            input logic [PC_W-1:0] npc);
    chk(req, "pred_valid", 32'(pred_valid), 32'd1);
    chk(req, "pred_hit",   32'(pred_hit),   32'(h));
    chk(req, "pred_taken", 32'(pred_taken), 32'(t));
    chk(req, "pred_pc",    pred_pc,         npc);
  endtask

  // lookup alone; returns what fetch would carry with the branch
  task automatic look(input logic [PC_W-1:0] pc, input string req,
                      output logic pt, output logic [PC_W-1:0] ptg);
    logic h;
    m_predict(pc, h, pt, ptg);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_pc    = pc;
    @(negedge clk);
    lk_valid = 1'b0;
    check_pred(req, h, pt, ptg);
  endtask

  task automatic check_flush(input logic [PC_W-1:0] pc, input logic tk,
                             input logic [PC_W-1:0] tgt, input logic pt,
                             input logic [PC_W-1:0] ptg);
    logic  ef;
    string req;
    ef = (pt != tk) || (pt && tk && (ptg != tgt));
    if (pt && !tk)                  req = "R7";
    else if (!pt && tk)             req = "R8";
    else if (pt && tk && ptg != tgt) req = "R9";
    else                            req = "R10";
    chk(req, "flush", 32'(flush), 32'(ef));
    if (ef) chk(req, "flush_pc", flush_pc, tk ? tgt : pc + 32'd4);
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input logic tk,
                     input logic [PC_W-1:0] tgt, input logic pt,
                     input logic [PC_W-1:0] ptg);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
    upd_pred_taken = pt; upd_pred_target = ptg;
    @(negedge clk);
    upd_valid = 1'b0;
    check_flush(pc, tk, tgt, pt, ptg);
    m_train(pc, tk, tgt);
  endtask

  // lookup and update on the same edge (R11)
  task automatic both(input logic [PC_W-1:0] lpc, input logic [PC_W-1:0] pc,
                      input logic tk, input logic [PC_W-1:0] tgt,
                      input logic pt, input logic [PC_W-1:0] ptg);
    logic h, lt;
    logic [PC_W-1:0] npc;
    m_predict(lpc, h, lt, npc);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = lpc;
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
    upd_pred_taken = pt; upd_pred_target = ptg;
    @(negedge clk);
    lk_valid = 1'b0; upd_valid = 1'b0;
    check_pred("R11", h, lt, npc);
    check_flush(pc, tk, tgt, pt, ptg);
    m_train(pc, tk, tgt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic            pt;
    logic [PC_W-1:0] ptg;
    logic [PC_W-1:0] pa, pb, pc_c, pd;
    for (int i = 0; i < DEPTH; i++) begin
      m_vld[i] = 1'b0; m_tag[i] = '0; m_ctr[i] = 2'd0; m_tgt[i] = '0;
    end
    pa = 32'h0000_1004; pb = 32'h0000_2008; pc_c = 32'h0000_300C; pd = 32'h0000_700C;
    rst = 1'b1; lk_valid = 1'b0; lk_pc = '0; upd_valid = 1'b0; upd_pc = '0;
    upd_taken = 1'b0; upd_target = '0; upd_pred_taken = 1'b0; upd_pred_target = '0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    chk("R1", "pred_valid in reset", 32'(pred_valid), 32'd0);
    chk("R1", "flush in reset", 32'(flush), 32'd0);
    rst = 1'b0;
    look(pa, "R1", pt, ptg);
    chk("R1", "miss next pc", ptg, pa + 32'd4);

    // R4 taken allocation, R8 flush, then R2 lookup of stored target
    upd(pa, 1'b1, 32'h0000_4000, pt, ptg);
    look(pa, "R2", pt, ptg);
    chk("R4", "weakly taken predicts target", ptg, 32'h0000_4000);
    // R5: one not-taken drops to weakly not taken (R7 flush)
    upd(pa, 1'b0, 32'h0000_4000, pt, ptg);
    look(pa, "R5", pt, ptg);
    chk("R5", "weak taken stepped down", 32'(pt), 32'd0);

    // R4 not-taken allocation, R10 no flush
    look(pb, "R3", pt, ptg);
    upd(pb, 1'b0, 32'h0000_5000, pt, ptg);
    look(pb, "R4", pt, ptg);
    chk("R4", "weakly not taken", 32'(pt), 32'd0);

    // R6 / R13: strong taken survives one not-taken, target kept
    look(pc_c, "R3", pt, ptg);
    upd(pc_c, 1'b1, 32'h0000_6000, pt, ptg);
    look(pc_c, "R5", pt, ptg);
    upd(pc_c, 1'b1, 32'h0000_6000, pt, ptg);
    look(pc_c, "R6", pt, ptg);
    upd(pc_c, 1'b0, 32'h0000_6100, pt, ptg);
    look(pc_c, "R6", pt, ptg);
    chk("R6", "still taken", 32'(pt), 32'd1);
    chk("R13", "target kept", ptg, 32'h0000_6000);

    // R9: taken to a new target
    upd(pc_c, 1'b1, 32'h0000_6800, pt, ptg);
    look(pc_c, "R9", pt, ptg);
    chk("R9", "target replaced", ptg, 32'h0000_6800);

    // R11: same-edge lookup sees old slot; two not-taken updates
    both(pc_c, pc_c, 1'b0, 32'h0000_6800, 1'b1, 32'h0000_6800);
    both(pc_c, pc_c, 1'b0, 32'h0000_6800, 1'b1, 32'h0000_6800);
    look(pc_c, "R5", pt, ptg);

    // R12: alias with a different tag replaces the slot
    upd(pd, 1'b1, 32'h0000_7700, 1'b0, 32'h0);
    look(pc_c, "R12", pt, ptg);
    chk("R12", "old address misses", 32'(pred_hit), 32'd0);
    look(pd, "R12", pt, ptg);

    // sweep every slot with two aliasing tags and a varied outcome stream
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < DEPTH; i++) begin
        logic [PC_W-1:0] spc;
        spc = {TAG_W'(1000 + r * 37 + i), IDX_W'(i), 2'b00};
        for (int s = 0; s < 12; s++) begin
          logic            tk;
          logic [PC_W-1:0] tg;
          tk = 1'((16'hD38E >> ((i * 3 + s + r) % 16)) & 16'h1);
          tg = spc + 32'(((s % 4) == 3) ? 512 : 256) + 32'(r * 16);
          look(spc, "R2", pt, ptg);
          upd(spc, tk, tg, pt, ptg);
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule